// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block runs the command protocol of a 32-bit flash data path made of two 16-bit devices wired side by side. A requester asks for one of three jobs: erase the block that holds an address, program one 32-bit word, or read the identifier codes to confirm that a supported device is fitted. The sequencer then issues the command writes and reads on a synchronous bus port. Each command byte goes into the low byte of every 16-bit lane, so both devices receive the same command.

For erase and program jobs the block polls the device status until every lane reports ready. It then puts the devices back into array-read mode and only after that judges the outcome. A program job also reads the word back and compares it with the data written. If the ready bit never appears within a fixed number of polls, the job ends with a timeout.

The bus port has one cycle of read latency: the data for a read issued in cycle N is present on `bus_rdata` in cycle N+1. Requests are taken only while the block is idle. Completion is a one-cycle `rsp_done` pulse, and the result flags are valid during that pulse.

Top module: `nor_cmd_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_done`, `bus_we` and `bus_re` are all low.
- R2: An erase request (`req_op` = 0) writes 0x00200020 and then 0x00D000D0 to the request address in two consecutive cycles.
- R3: A status poll writes 0x00700070 to the operation address and reads that address in the next cycle. Polling repeats until bit 7 and bit 23 of the status word are both set; if only one lane is ready, polling continues.
- R4: When polling ends, 0x00FF00FF is written to the operation address before `rsp_done` is raised.
- R5: An erase reports `rsp_err` when bit 5 or bit 21 is set in the final status word.
- R6: A program request (`req_op` = 1) writes 0x00400040 and then the request data to the request address in consecutive cycles, then polls as in R3. It reports an error when bit 4 or bit 20 of the final status is set.
- R7: After returning to array-read mode, a program reads the address once. If the word read differs from the data written, `rsp_err` is set.
- R8: A probe request (`req_op` = 2) writes 0x00900090 at address 0, reads addresses 0 and 1, and writes 0x00FF00FF at address 0. `rsp_match` is set only when word 0 is 0x00890089 and word 1 is 0x88F388F3 or 0x88F488F4. A probe never sets `rsp_err`.
- R9: If POLL_MAX status reads in a row all show not-ready, the job stops polling, writes array-read as in R4, and completes with both `rsp_timeout` and `rsp_err` set.
- R10: A request that arrives while a job is running, and a request with `req_op` = 3, produce no bus activity and no completion.
- R11: `rsp_done` is high for exactly one cycle per accepted job.
- R12: `bus_we` and `bus_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Request strobe, taken only when idle |
| req_op | input | 2 | 0 erase, 1 program, 2 probe, 3 no operation |
| req_addr | input | AW (20) | Word address for erase or program |
| req_data | input | 16*LANES (32) | Data word to program |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Job failed (valid with rsp_done) |
| rsp_timeout | output | 1 | Ready never seen (valid with rsp_done) |
| rsp_match | output | 1 | Probe found a supported device (valid with rsp_done) |
| bus_addr | output | AW (20) | Bus word address |
| bus_wdata | output | 16*LANES (32) | Bus write data |
| bus_we | output | 1 | Bus write strobe, one cycle per write |
| bus_re | output | 1 | Bus read strobe, one cycle per read |
| bus_rdata | input | 16*LANES (32) | Read data, valid the cycle after bus_re |

## Verification
The assertions assume the bus returns the addressed word exactly one cycle after `bus_re`. They also assume that `req_start` may arrive at any time, because the block itself filters requests that come while it is busy. The bench meets the latency assumption with a registered flash model. That model decodes the replicated command bytes, keeps per-job busy counts and error bits, and can report ready in only one lane. Busy-time requests are sent deliberately during an erase, to show that the filter works rather than that the stimulus avoids the case.

// File: rtl/nor_seq_pkg.sv
// Package: shared encodings for the NOR flash command sequencer.
// Assumes command bytes sit in the low byte of each 16-bit device lane.
package nor_seq_pkg;

    typedef enum logic [1:0] {
        OP_ERASE = 2'd0,
        OP_PROG  = 2'd1,
        OP_PROBE = 2'd2,
        OP_NONE  = 2'd3
    } seq_op_e;

    typedef enum logic [4:0] {
        S_IDLE,
        S_ER_SETUP,
        S_ER_CONF,
        S_PG_SETUP,
        S_PG_DATA,
        S_ST_CMD,
        S_ST_RD,
        S_ST_WAIT,
        S_RA_CMD,
        S_VF_RD,
        S_VF_WAIT,
        S_ID_CMD,
        S_ID_RD0,
        S_ID_RD1,
        S_ID_WAIT,
        S_ID_RA,
        S_FIN
    } seq_state_e;

    localparam logic [7:0] CMD_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_ER_SET  = 8'h20;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_PG_SET  = 8'h40;
    localparam logic [7:0] CMD_STATUS  = 8'h70;

    localparam int LANE_W  = 16;
    localparam int RDY_BIT = 7;
    localparam int ER_BIT  = 5;
    localparam int PG_BIT  = 4;

    localparam logic [15:0] ID_MAKER = 16'h0089;
    localparam logic [15:0] ID_DEV_T = 16'h88F3;
    localparam logic [15:0] ID_DEV_B = 16'h88F4;

endpackage

// File: rtl/nor_poll_limit.sv
// Module: counts not-ready status polls and flags the last allowed one.
// Assumes clr is asserted while idle, before every job.
module nor_poll_limit #(
    parameter int POLL_MAX = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = $clog2(POLL_MAX + 1);

    logic [CW-1:0] cnt_q;

    // Counts not-ready polls of the current job.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit = (cnt_q == CW'(POLL_MAX - 1));

    p_cnt_below_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (cnt_q < CW'(POLL_MAX)));
endmodule

// File: rtl/nor_lane_status.sv
// Module: reduces per-lane status bits and keeps the error flags of the final poll.
// Assumes each input vector holds one bit per device lane.
module nor_lane_status #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             capture,
    input  logic [LANES-1:0] rdy_v,
    input  logic [LANES-1:0] er_v,
    input  logic [LANES-1:0] pg_v,
    output logic             ready_all,
    output logic             er_q,
    output logic             pg_q
);
    assign ready_all = &rdy_v;

    // Holds the erase and program error flags of the final status word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            er_q <= 1'b0;
            pg_q <= 1'b0;
        end else if (capture) begin
            er_q <= |er_v;
            pg_q <= |pg_v;
        end
    end

    p_capture_only_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> ready_all);
endmodule

// File: rtl/nor_id_check.sv
// Module: decides whether the two identifier words name a supported device.
// Assumes every lane carries the same code; all lanes must agree on one device.
module nor_id_check #(
    parameter int LANES = 2
) (
    input  logic [16*LANES-1:0] maker_w,
    input  logic [16*LANES-1:0] dev_w,
    output logic                match
);
    import nor_seq_pkg::*;

    logic [LANES-1:0] mk_ok, dv_t, dv_b;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign mk_ok[l] = (maker_w[l*LANE_W +: LANE_W] == ID_MAKER);
        assign dv_t[l]  = (dev_w[l*LANE_W +: LANE_W]   == ID_DEV_T);
        assign dv_b[l]  = (dev_w[l*LANE_W +: LANE_W]   == ID_DEV_B);
    end

    assign match = (&mk_ok) && ((&dv_t) || (&dv_b));
endmodule

// File: rtl/nor_bus_drive.sv
// Module: decodes the sequencer state into one bus cycle of write or read.
// Assumes the state and operands are registered, so the outputs do not glitch.
module nor_bus_drive #(
    parameter int AW    = 20,
    parameter int LANES = 2
) (
    input  nor_seq_pkg::seq_state_e state,
    input  logic [AW-1:0]           op_addr,
    input  logic [16*LANES-1:0]     op_data,
    output logic [AW-1:0]           bus_addr,
    output logic [16*LANES-1:0]     bus_wdata,
    output logic                    bus_we,
    output logic                    bus_re
);
    import nor_seq_pkg::*;

    localparam int DW = 16 * LANES;

    function automatic logic [DW-1:0] rep(input logic [7:0] c);
        return {LANES{8'h00, c}};
    endfunction

    // Selects the strobe, address and data for the current state.
    always_comb begin
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        bus_addr  = op_addr;
        bus_wdata = '0;
        unique case (state)
            S_ER_SETUP: begin bus_we = 1'b1; bus_wdata = rep(CMD_ER_SET);  end
            S_ER_CONF:  begin bus_we = 1'b1; bus_wdata = rep(CMD_CONFIRM); end
            S_PG_SETUP: begin bus_we = 1'b1; bus_wdata = rep(CMD_PG_SET);  end
            S_PG_DATA:  begin bus_we = 1'b1; bus_wdata = op_data;          end
            S_ST_CMD:   begin bus_we = 1'b1; bus_wdata = rep(CMD_STATUS);  end
            S_ST_RD:    begin bus_re = 1'b1;                               end
            S_RA_CMD:   begin bus_we = 1'b1; bus_wdata = rep(CMD_ARRAY);   end
            S_VF_RD:    begin bus_re = 1'b1;                               end
            S_ID_CMD:   begin bus_we = 1'b1; bus_wdata = rep(CMD_IDENT); bus_addr = '0; end
            S_ID_RD0:   begin bus_re = 1'b1; bus_addr = '0;                end
            S_ID_RD1:   begin bus_re = 1'b1; bus_addr = AW'(1);            end
            S_ID_RA:    begin bus_we = 1'b1; bus_wdata = rep(CMD_ARRAY); bus_addr = '0; end
            default:    begin end
        endcase
    end
endmodule

// File: rtl/nor_cmd_seq.sv
// Module: top of the NOR flash command sequencer (erase, program, probe).
// Assumes bus read data arrives one cycle after bus_re; requests are taken only when idle.
module nor_cmd_seq #(
    parameter int AW       = 20,
    parameter int LANES    = 2,
    parameter int POLL_MAX = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_start,
    input  logic [1:0]          req_op,
    input  logic [AW-1:0]       req_addr,
    input  logic [16*LANES-1:0] req_data,
    output logic                rsp_done,
    output logic                rsp_err,
    output logic                rsp_timeout,
    output logic                rsp_match,
    output logic [AW-1:0]       bus_addr,
    output logic [16*LANES-1:0] bus_wdata,
    output logic                bus_we,
    output logic                bus_re,
    input  logic [16*LANES-1:0] bus_rdata
);
    import nor_seq_pkg::*;

    localparam int DW = 16 * LANES;

    function automatic logic [DW-1:0] rep(input logic [7:0] c);
        return {LANES{8'h00, c}};
    endfunction

    seq_state_e       state;
    seq_op_e          op_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    data_q;
    logic [DW-1:0]    maker_q, dev_q;
    logic             tmo_q, vfail_q;
    logic [LANES-1:0] rdy_v, er_v, pg_v;
    logic             ready_all, er_q, pg_q, at_limit, id_match, fail;
    logic             in_wait;

    // Picks the status bits of each lane out of the read word.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign rdy_v[l] = bus_rdata[l*LANE_W + RDY_BIT];
        assign er_v[l]  = bus_rdata[l*LANE_W + ER_BIT];
        assign pg_v[l]  = bus_rdata[l*LANE_W + PG_BIT];
    end

    assign in_wait = (state == S_ST_WAIT);

    nor_lane_status #(.LANES(LANES)) u_status (
        .clk(clk), .rst_n(rst_n), .clr(state == S_IDLE),
        .capture(in_wait && ready_all),
        .rdy_v(rdy_v), .er_v(er_v), .pg_v(pg_v),
        .ready_all(ready_all), .er_q(er_q), .pg_q(pg_q)
    );

    nor_poll_limit #(.POLL_MAX(POLL_MAX)) u_poll (
        .clk(clk), .rst_n(rst_n), .clr(state == S_IDLE),
        .inc(in_wait && !ready_all), .at_limit(at_limit)
    );

    nor_id_check #(.LANES(LANES)) u_id (
        .maker_w(maker_q), .dev_w(dev_q), .match(id_match)
    );

    nor_bus_drive #(.AW(AW), .LANES(LANES)) u_drive (
        .state(state), .op_addr(addr_q), .op_data(data_q),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re)
    );

    // Main sequencer: accepts requests when idle and steps through bus cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            op_q    <= OP_NONE;
            addr_q  <= '0;
            data_q  <= '0;
            maker_q <= '0;
            dev_q   <= '0;
            tmo_q   <= 1'b0;
            vfail_q <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req_start && seq_op_e'(req_op) != OP_NONE) begin
                        op_q    <= seq_op_e'(req_op);
                        addr_q  <= (seq_op_e'(req_op) == OP_PROBE) ? '0 : req_addr;
                        data_q  <= req_data;
                        tmo_q   <= 1'b0;
                        vfail_q <= 1'b0;
                        unique case (seq_op_e'(req_op))
                            OP_ERASE: state <= S_ER_SETUP;
                            OP_PROG:  state <= S_PG_SETUP;
                            default:  state <= S_ID_CMD;
                        endcase
                    end
                end
                S_ER_SETUP: state <= S_ER_CONF;
                S_ER_CONF:  state <= S_ST_CMD;
                S_PG_SETUP: state <= S_PG_DATA;
                S_PG_DATA:  state <= S_ST_CMD;
                S_ST_CMD:   state <= S_ST_RD;
                S_ST_RD:    state <= S_ST_WAIT;
                S_ST_WAIT: begin
                    if (ready_all) begin
                        state <= S_RA_CMD;
                    end else if (at_limit) begin
                        tmo_q <= 1'b1;
                        state <= S_RA_CMD;
                    end else begin
                        state <= S_ST_CMD;
                    end
                end
                S_RA_CMD:   state <= (op_q == OP_PROG && !tmo_q) ? S_VF_RD : S_FIN;
                S_VF_RD:    state <= S_VF_WAIT;
                S_VF_WAIT: begin
                    vfail_q <= (bus_rdata != data_q);
                    state   <= S_FIN;
                end
                S_ID_CMD:   state <= S_ID_RD0;
                S_ID_RD0:   state <= S_ID_RD1;
                S_ID_RD1: begin
                    maker_q <= bus_rdata;
                    state   <= S_ID_WAIT;
                end
                S_ID_WAIT: begin
                    dev_q <= bus_rdata;
                    state <= S_ID_RA;
                end
                S_ID_RA:    state <= S_FIN;
                default:    state <= S_IDLE;
            endcase
        end
    end

    // Combines the recorded flags into the job result.
    always_comb begin
        unique case (op_q)
            OP_ERASE: fail = er_q || tmo_q;
            OP_PROG:  fail = pg_q || tmo_q || vfail_q;
            default:  fail = 1'b0;
        endcase
    end

    assign rsp_done    = (state == S_FIN);
    assign rsp_err     = rsp_done && fail;
    assign rsp_timeout = rsp_done && tmo_q;
    assign rsp_match   = rsp_done && (op_q == OP_PROBE) && id_match;

    p_no_we_re_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));
    p_confirm_after_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ER_SETUP) |=> (bus_we && bus_wdata == rep(CMD_CONFIRM) && $stable(bus_addr)));
    p_data_after_pgsetup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && state == S_PG_SETUP) |=> (bus_we && $stable(bus_addr)));
    p_read_after_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_wdata == rep(CMD_STATUS) && state == S_ST_CMD) |=> (bus_re && $stable(bus_addr)));
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    p_timeout_is_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_timeout |-> rsp_err);
    p_quiet_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!bus_we && !bus_re));
endmodule

// File: tb/nor_cmd_seq_test.sv
module nor_cmd_seq_test;
    localparam int AW   = 20;
    localparam int PMAX = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic [1:0]  req_op = 2'd3;
    logic [19:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic        rsp_done, rsp_err, rsp_timeout, rsp_match;
    logic [19:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we, bus_re;
    logic [31:0] bus_rdata = '0;

    always #5 clk = ~clk;

    nor_cmd_seq #(.AW(AW), .LANES(2), .POLL_MAX(PMAX)) uut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .rsp_done(rsp_done),
        .rsp_err(rsp_err), .rsp_timeout(rsp_timeout), .rsp_match(rsp_match),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_re(bus_re), .bus_rdata(bus_rdata)
    );

    int nchk = 0, nerr = 0;
    // flash model state
    logic [31:0] mem [16];
    int          mode = 0;          // 0 array, 1 status, 2 identifier
    int          busy_left = 0;
    int          cfg_busy = 0;
    logic        cfg_half = 1'b0;
    logic [31:0] cfg_stat = '0;
    logic [31:0] cfg_corrupt = '0;
    logic [31:0] id_mk = 32'h00890089, id_dv = 32'h88F388F3;
    logic        pg_pend = 1'b0;
    logic [31:0] wl_a [64];
    logic [31:0] wl_d [64];
    int          wcnt = 0, rcnt = 0, ndone = 0, novl = 0;
    logic        r_err, r_tmo, r_match;

    // flash model: decodes writes, answers reads one cycle later
    always @(posedge clk) begin
        if (bus_we) begin
            if (wcnt < 64) begin wl_a[wcnt] = 32'(bus_addr); wl_d[wcnt] = bus_wdata; end
            wcnt++;
            if (pg_pend) begin
                mem[bus_addr[3:0]] = bus_wdata ^ cfg_corrupt;
                pg_pend = 1'b0; busy_left = cfg_busy; mode = 1;
            end else begin
                case (bus_wdata)
                    32'h00FF00FF: mode = 0;
                    32'h00900090: mode = 2;
                    32'h00700070: mode = 1;
                    32'h00400040: pg_pend = 1'b1;
                    32'h00D000D0: begin mem[bus_addr[3:0]] = 32'hFFFFFFFF; busy_left = cfg_busy; mode = 1; end
                    default: ;
                endcase
            end
        end
        if (bus_re) begin
            rcnt++;
            if (mode == 0) bus_rdata <= mem[bus_addr[3:0]];
            else if (mode == 2) bus_rdata <= (bus_addr == 20'd0) ? id_mk : id_dv;
            else if (busy_left > 0) begin
                bus_rdata <= cfg_half ? 32'h00000080 : 32'h0;
                busy_left = busy_left - 1;
            end else bus_rdata <= 32'h00800080 | cfg_stat;
        end
        if (rsp_done) ndone++;
    end

    always @(negedge clk) if (bus_we && bus_re) novl++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int count_wr(input logic [31:0] v);
        int n = 0;
        for (int i = 0; i < wcnt && i < 64; i++) if (wl_d[i] == v) n++;
        return n;
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [19:0] a, input logic [31:0] d);
        logic got = 1'b0;
        wcnt = 0; rcnt = 0;
        @(negedge clk);
        req_start = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk);
        req_start = 1'b0;
        for (int i = 0; i < 3000 && !got; i++) begin
            if (rsp_done) begin
                got = 1'b1; r_err = rsp_err; r_tmo = rsp_timeout; r_match = rsp_match;
            end else @(negedge clk);
        end
        if (!got) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual no done expected done");
        end
        @(negedge clk);
        chk("R11 done one cycle", 32'(rsp_done), 0);
    endtask

    task automatic t_reset;
        chk("R1 done in reset", 32'(rsp_done), 0);
        chk("R1 we in reset", 32'(bus_we), 0);
        chk("R1 re in reset", 32'(bus_re), 0);
    endtask

    task automatic t_erase_ok;
        cfg_busy = 2; cfg_stat = 0; cfg_half = 0;
        run_op(2'd0, 20'h00A40, 0);
        chk("R2 first write", wl_d[0], 32'h00200020);
        chk("R2 first addr", wl_a[0], 32'h00A40);
        chk("R2 second write", wl_d[1], 32'h00D000D0);
        chk("R2 second addr", wl_a[1], 32'h00A40);
        chk("R3 status writes", 32'(count_wr(32'h00700070)), 3);
        chk("R3 status reads", 32'(rcnt), 3);
        chk("R4 last write", wl_d[5], 32'h00FF00FF);
        chk("R4 write count", 32'(wcnt), 6);
        chk("R5 erase clean", 32'(r_err), 0);
    endtask

    task automatic t_erase_fail;
        cfg_busy = 0; cfg_stat = 32'h00000020;
        run_op(2'd0, 20'h00003, 0);
        chk("R5 erase err low lane", 32'(r_err), 1);
        cfg_stat = 32'h00200000;
        run_op(2'd0, 20'h00003, 0);
        chk("R5 erase err high lane", 32'(r_err), 1);
        chk("R5 not timeout", 32'(r_tmo), 0);
        cfg_stat = 0;
    endtask

    task automatic t_half_ready;
        cfg_busy = 3; cfg_half = 1'b1;
        run_op(2'd0, 20'h00002, 0);
        chk("R3 one lane ready keeps polling", 32'(count_wr(32'h00700070)), 4);
        chk("R3 half ready result", 32'(r_err), 0);
        cfg_half = 1'b0;
    endtask

    task automatic t_prog;
        cfg_busy = 1; cfg_stat = 0; cfg_corrupt = 0;
        run_op(2'd1, 20'h00005, 32'h12345678);
        chk("R6 setup write", wl_d[0], 32'h00400040);
        chk("R6 data write", wl_d[1], 32'h12345678);
        chk("R6 data addr", wl_a[1], 32'h00005);
        chk("R4 array before verify", wl_d[wcnt-1], 32'h00FF00FF);
        chk("R7 reads incl verify", 32'(rcnt), 3);
        chk("R6 program ok", 32'(r_err), 0);
        cfg_stat = 32'h00100000;
        run_op(2'd1, 20'h00006, 32'hCAFEF00D);
        chk("R6 program status err", 32'(r_err), 1);
        cfg_stat = 0; cfg_corrupt = 32'h00010000;
        run_op(2'd1, 20'h00007, 32'h0BADBEEF);
        chk("R7 readback mismatch err", 32'(r_err), 1);
        chk("R7 mismatch not timeout", 32'(r_tmo), 0);
        cfg_corrupt = 0;
    endtask

    task automatic t_probe;
        id_mk = 32'h00890089; id_dv = 32'h88F388F3;
        run_op(2'd2, 20'h00777, 0);
        chk("R8 ident cmd", wl_d[0], 32'h00900090);
        chk("R8 ident addr 0", wl_a[0], 0);
        chk("R8 restore array", wl_d[1], 32'h00FF00FF);
        chk("R8 restore addr 0", wl_a[1], 0);
        chk("R8 two reads", 32'(rcnt), 2);
        chk("R8 match top", 32'(r_match), 1);
        chk("R8 probe no err", 32'(r_err), 0);
        id_dv = 32'h88F488F4;
        run_op(2'd2, 0, 0);
        chk("R8 match bottom", 32'(r_match), 1);
        id_dv = 32'h88F188F1;
        run_op(2'd2, 0, 0);
        chk("R8 small device no match", 32'(r_match), 0);
        id_dv = 32'h88F388F4;
        run_op(2'd2, 0, 0);
        chk("R8 mixed lanes no match", 32'(r_match), 0);
        id_mk = 32'h00890000; id_dv = 32'h88F388F3;
        run_op(2'd2, 0, 0);
        chk("R8 bad maker no match", 32'(r_match), 0);
        id_mk = 32'h00890089;
    endtask

    task automatic t_timeout;
        cfg_busy = 1000;
        run_op(2'd0, 20'h00001, 0);
        chk("R9 status reads", 32'(count_wr(32'h00700070)), PMAX);
        chk("R9 timeout flag", 32'(r_tmo), 1);
        chk("R9 err flag", 32'(r_err), 1);
        chk("R9 array restored", wl_d[wcnt-1], 32'h00FF00FF);
        cfg_busy = 1000;
        run_op(2'd1, 20'h00001, 32'h5);
        chk("R9 program timeout no verify", 32'(rcnt), PMAX);
        chk("R9 program timeout err", 32'(r_err), 1);
        busy_left = 0; cfg_busy = 0;
    endtask

    task automatic t_ignored;
        int d0;
        // op 3 while idle
        wcnt = 0; rcnt = 0; d0 = ndone;
        @(negedge clk); req_start = 1'b1; req_op = 2'd3;
        @(negedge clk); req_start = 1'b0;
        repeat (10) @(negedge clk);
        chk("R10 op3 no writes", 32'(wcnt), 0);
        chk("R10 op3 no reads", 32'(rcnt), 0);
        chk("R10 op3 no done", 32'(ndone - d0), 0);
        // request during a running erase
        cfg_busy = 4; wcnt = 0; rcnt = 0; d0 = ndone;
        @(negedge clk); req_start = 1'b1; req_op = 2'd0; req_addr = 20'h00009;
        @(negedge clk); req_start = 1'b0;
        repeat (3) @(negedge clk);
        req_start = 1'b1; req_op = 2'd1; req_data = 32'h77;
        @(negedge clk); req_start = 1'b0;
        repeat (40) @(negedge clk);
        chk("R10 busy request no program", 32'(count_wr(32'h00400040)), 0);
        chk("R10 erase writes only", 32'(wcnt), 8);
        chk("R10 one completion", 32'(ndone - d0), 1);
        cfg_busy = 0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h01010101 * i;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset done", 32'(rsp_done), 0);
        chk("R1 idle after reset we", 32'(bus_we | bus_re), 0);
        t_erase_ok();
        t_erase_fail();
        t_half_ready();
        t_prog();
        t_probe();
        t_timeout();
        t_ignored();
        chk("R12 we and re overlap", 32'(novl), 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule